// File: doc/BRIEF.md
# Privilege Level Exception Controller

This block holds the privilege state of a processor core. That state is a level from 0 to 3, a data-width flag (32-bit or 64-bit) and a stack choice (the shared level-0 stack or the current level's own stack). A higher level number means more privilege. The level changes only when an exception is taken or when an exception return completes. The pipeline asks for an exception with `take_req`, giving the exception kind, the target level and the address to resume at. It asks for a return with `ret_req`. The block answers one cycle later. It pulses `pc_load` with the fetch address, or it pulses `fault` when the request breaks a transition rule.

Each level above 0 has its own bank of three registers: a vector base, a saved-state word and a return address. When an exception is taken, the block stores the current state and the resume address in the target level's bank, switches to the target level's own stack, and computes the handler address from that level's vector base. When an exception is returned from, the block restores the state and the fetch address from the bank of the level being left. A small write port loads the banks. Every vector base must be loaded before an exception to its level is accepted.

Parameters select whether levels 2 and 3 are present. `NARROW_LEVELS` sets how many of the lowest levels may run 32-bit code. Because it counts from level 0 upward, any level that allows 32-bit code also has every level below it allowing 32-bit code.

Top module: `priv_exc_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `cur_lvl` is the highest level present (3 by default), `cur_is64`=1, `sp_own`=1, `fault`=0 and `pc_load`=0.
- R2: A legal take request moves `cur_lvl` to `take_lvl` and sets `sp_own`=1 in the following cycle. In that same cycle `pc_load` is high for one cycle and `fault` is low.
- R3: The handler address is `{vbase[AW-1:11], off}`. The 11-bit `off` is `exc_kind`×0x80, where 0 is synchronous, 1 is IRQ, 2 is fast interrupt and 3 is system error. An extra 0x200 is added when `take_lvl` equals the current level and `sp_own` was 1.
- R4: An accepted take stores `{sp_own, cur_is64, cur_lvl}` and `ret_pc` in the target level's bank. A later return from that level restores exactly those values.
- R5: On an accepted take, `cur_is64` stays 1 if it was already 1. If it was 0, it stays 0 only when `take_lvl` < `NARROW_LEVELS`; otherwise it becomes 1.
- R6: A take request is refused, with `fault`=1, `pc_load`=0 and the state unchanged, in any of these cases: `take_lvl` is 0; `take_lvl` is below the current level; the target level is absent; the target level's vector base has not been written since reset.
- R7: A legal return loads `pc_out` from the current level's return address, and takes level and width from its saved-state word. `sp_own` comes from the saved word, except that it is forced to 0 when the restored level is 0.
- R8: A return request is refused, with `fault`=1 and the state unchanged, in any of these cases: the current level is 0; the saved level is above the current level; the saved level is absent; the saved word asks for 32-bit at a level ≥ `NARROW_LEVELS`; the saved word asks for 64-bit while `cur_is64`=0.
- R9: When `take_req` and `ret_req` are high in the same cycle, only the take is acted on.
- R10: A configuration write applies `cfg_data` to the bank of level `cfg_lvl`. The target register is chosen by `cfg_sel`: 0 is the vector base, 1 is the saved-state word with bit 3 = stack, bit 2 = 64-bit and bits 1:0 = level, and 2 is the return address.
- R11: `cur_lvl` does not change in a cycle that follows one with no take and no return request.
- R12: `pc_load` and `fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_req | input | 1 | Exception take request |
| exc_kind | input | 2 | Exception kind for vector offset |
| take_lvl | input | 2 | Target level of the exception |
| ret_pc | input | AW | Address to resume at, stored on take |
| ret_req | input | 1 | Exception return request |
| cfg_wr | input | 1 | Bank register write strobe |
| cfg_sel | input | 2 | Bank register select |
| cfg_lvl | input | 2 | Bank level written |
| cfg_data | input | AW | Write data |
| pc_load | output | 1 | New fetch address valid (one cycle) |
| pc_out | output | AW | New fetch address |
| cur_lvl | output | 2 | Current privilege level |
| cur_is64 | output | 1 | Current width is 64-bit |
| sp_own | output | 1 | 1 selects the current level's own stack, 0 the level-0 stack |
| fault | output | 1 | Refused request (one cycle) |

## Verification
The properties assume that every request and configuration input is driven to a known value in each cycle after reset. They also assume that each one-cycle request is judged only against the state present at that edge. The bench drives every input at the falling edge from fixed-seed random draws and directed steps, and it returns all inputs to zero after each edge. Random saved-state words cover legal and illegal return targets alike. Take levels and kinds are drawn over their full ranges, so refused requests occur as often as accepted ones.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

    typedef enum logic [1:0] {
        EXC_SYNC   = 2'd0,
        EXC_IRQ    = 2'd1,
        EXC_FIRQ   = 2'd2,
        EXC_SYSERR = 2'd3
    } exc_kind_e;

    typedef enum logic [1:0] {
        CFG_VBASE = 2'd0,
        CFG_SAVED = 2'd1,
        CFG_RETPC = 2'd2,
        CFG_NONE  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic       sp_own;
        logic       is64;
        logic [1:0] lvl;
    } pstate_t;

    localparam int unsigned VEC_ALIGN_BITS = 11;
    localparam int unsigned VEC_SLOT_SHIFT = 7;
    localparam logic [10:0] VEC_SAME_OWN   = 11'h200;

    function automatic logic lvl_present(input logic [1:0] l, input bit has2, input bit has3);
        case (l)
            2'd2:    return has2;
            2'd3:    return has3;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic narrow_ok(input logic [1:0] l, input int unsigned nlv);
        return {30'd0, l} < nlv;
    endfunction

endpackage

// File: rtl/pxc_bank.sv
module pxc_bank
    import pxc_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter bit          HAS_L2 = 1'b1,
    parameter bit          HAS_L3 = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [1:0]           cfg_sel,
    input  logic [1:0]           cfg_lvl,
    input  logic [AW-1:0]        cfg_data,
    input  logic                 save_en,
    input  logic [1:0]           save_lvl,
    input  pstate_t              save_state,
    input  logic [AW-1:0]        save_pc,
    output logic [3:0][AW-1:0]   vbase,
    output logic [3:0]           vb_valid,
    output pstate_t [3:0]        saved,
    output logic [3:0][AW-1:0]   retpc
);

    for (genvar g = 0; g < 4; g++) begin : g_lvl
        localparam bit PRES = (g == 1) || (g == 2 && HAS_L2) || (g == 3 && HAS_L3);
        if (PRES) begin : g_on
            logic [AW-1:0] vb_q;
            logic          vv_q;
            pstate_t       sv_q;
            logic [AW-1:0] rp_q;
            logic          hit_cfg;
            logic          hit_save;

            assign hit_cfg  = cfg_wr && (cfg_lvl == 2'(g));
            assign hit_save = save_en && (save_lvl == 2'(g));

            always_ff @(posedge clk) begin
                if (rst) begin
                    vb_q <= '0;
                    vv_q <= 1'b0;
                    sv_q <= '0;
                    rp_q <= '0;
                end else begin
                    if (hit_cfg && cfg_sel == CFG_VBASE) begin
                        vb_q <= cfg_data;
                        vv_q <= 1'b1;
                    end
                    if (hit_save) begin
                        sv_q <= save_state;
                        rp_q <= save_pc;
                    end else begin
                        if (hit_cfg && cfg_sel == CFG_SAVED) sv_q <= pstate_t'(cfg_data[3:0]);
                        if (hit_cfg && cfg_sel == CFG_RETPC) rp_q <= cfg_data;
                    end
                end
            end

            assign vbase[g]    = vb_q;
            assign vb_valid[g] = vv_q;
            assign saved[g]    = sv_q;
            assign retpc[g]    = rp_q;
        end else begin : g_off
            assign vbase[g]    = '0;
            assign vb_valid[g] = 1'b0;
            assign saved[g]    = '0;
            assign retpc[g]    = '0;
        end
    end

endmodule

// File: rtl/pxc_rules.sv
module pxc_rules
    import pxc_pkg::*;
#(
    parameter bit          HAS_L2        = 1'b1,
    parameter bit          HAS_L3        = 1'b1,
    parameter int unsigned NARROW_LEVELS = 2
) (
    input  pstate_t    cur,
    input  logic       take_req,
    input  logic [1:0] take_lvl,
    input  logic       ret_req,
    input  logic [3:0] vb_valid,
    input  pstate_t    saved_cur,
    output logic       take_go,
    output logic       ret_go,
    output logic       bad,
    output pstate_t    next_st
);

    logic take_ok;
    logic ret_ok;

    always_comb begin
        take_ok = (take_lvl != 2'd0) && (take_lvl >= cur.lvl)
               && lvl_present(take_lvl, HAS_L2, HAS_L3) && vb_valid[take_lvl];

        ret_ok = (cur.lvl != 2'd0) && (saved_cur.lvl <= cur.lvl)
              && lvl_present(saved_cur.lvl, HAS_L2, HAS_L3)
              && (saved_cur.is64 || narrow_ok(saved_cur.lvl, NARROW_LEVELS))
              && !(saved_cur.is64 && !cur.is64);

        take_go = take_req && take_ok;
        ret_go  = ret_req && !take_req && ret_ok;
        bad     = take_req ? !take_ok : (ret_req && !ret_ok);

        next_st = cur;
        if (take_go) begin
            next_st.lvl    = take_lvl;
            next_st.is64   = cur.is64 || !narrow_ok(take_lvl, NARROW_LEVELS);
            next_st.sp_own = 1'b1;
        end else if (ret_go) begin
            next_st.lvl    = saved_cur.lvl;
            next_st.is64   = saved_cur.is64;
            next_st.sp_own = (saved_cur.lvl != 2'd0) && saved_cur.sp_own;
        end
    end

endmodule

// File: rtl/pxc_vector.sv
module pxc_vector
    import pxc_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] vbase,
    input  logic [1:0]    kind,
    input  logic          same_own,
    output logic [AW-1:0] addr
);

    logic [VEC_ALIGN_BITS-1:0] off;

    always_comb begin
        off  = VEC_ALIGN_BITS'(kind) << VEC_SLOT_SHIFT;
        if (same_own) off = off + VEC_SAME_OWN;
        addr = {vbase[AW-1:VEC_ALIGN_BITS], off};
    end

endmodule

// File: rtl/priv_exc_ctrl.sv
module priv_exc_ctrl
    import pxc_pkg::*;
#(
    parameter int unsigned AW            = 32,
    parameter bit          HAS_L2        = 1'b1,
    parameter bit          HAS_L3        = 1'b1,
    parameter int unsigned NARROW_LEVELS = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take_req,
    input  logic [1:0]    exc_kind,
    input  logic [1:0]    take_lvl,
    input  logic [AW-1:0] ret_pc,
    input  logic          ret_req,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [1:0]    cfg_lvl,
    input  logic [AW-1:0] cfg_data,
    output logic          pc_load,
    output logic [AW-1:0] pc_out,
    output logic [1:0]    cur_lvl,
    output logic          cur_is64,
    output logic          sp_own,
    output logic          fault
);

    localparam logic [1:0] TOP_LVL = HAS_L3 ? 2'd3 : (HAS_L2 ? 2'd2 : 2'd1);

    pstate_t              st_q;
    pstate_t              st_d;
    logic [3:0][AW-1:0]   vbase;
    logic [3:0]           vb_valid;
    pstate_t [3:0]        saved;
    logic [3:0][AW-1:0]   retpc;
    logic                 take_go;
    logic                 ret_go;
    logic                 bad;
    logic                 same_own;
    logic [AW-1:0]        vec_addr;
    logic                 pcl_q;
    logic                 flt_q;
    logic [AW-1:0]        pc_q;

    pxc_bank #(.AW(AW), .HAS_L2(HAS_L2), .HAS_L3(HAS_L3)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_lvl    (cfg_lvl),
        .cfg_data   (cfg_data),
        .save_en    (take_go),
        .save_lvl   (take_lvl),
        .save_state (st_q),
        .save_pc    (ret_pc),
        .vbase      (vbase),
        .vb_valid   (vb_valid),
        .saved      (saved),
        .retpc      (retpc)
    );

    pxc_rules #(.HAS_L2(HAS_L2), .HAS_L3(HAS_L3), .NARROW_LEVELS(NARROW_LEVELS)) u_rules (
        .cur       (st_q),
        .take_req  (take_req),
        .take_lvl  (take_lvl),
        .ret_req   (ret_req),
        .vb_valid  (vb_valid),
        .saved_cur (saved[st_q.lvl]),
        .take_go   (take_go),
        .ret_go    (ret_go),
        .bad       (bad),
        .next_st   (st_d)
    );

    assign same_own = (take_lvl == st_q.lvl) && st_q.sp_own;

    pxc_vector #(.AW(AW)) u_vec (
        .vbase    (vbase[take_lvl]),
        .kind     (exc_kind),
        .same_own (same_own),
        .addr     (vec_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '{sp_own: 1'b1, is64: 1'b1, lvl: TOP_LVL};
            pcl_q <= 1'b0;
            flt_q <= 1'b0;
            pc_q  <= '0;
        end else begin
            st_q  <= st_d;
            pcl_q <= take_go || ret_go;
            flt_q <= bad;
            if (take_go)     pc_q <= vec_addr;
            else if (ret_go) pc_q <= retpc[st_q.lvl];
        end
    end

    assign pc_load  = pcl_q;
    assign fault    = flt_q;
    assign pc_out   = pc_q;
    assign cur_lvl  = st_q.lvl;
    assign cur_is64 = st_q.is64;
    assign sp_own   = st_q.sp_own;

endmodule

// File: rtl/pxc_checker.sv
module pxc_checker (
    input logic       clk,
    input logic       rst,
    input logic       take_req,
    input logic       ret_req,
    input logic       pc_load,
    input logic       fault,
    input logic [1:0] cur_lvl,
    input logic       cur_is64,
    input logic       sp_own
);

    // R12: accepted and refused never reported together
    a_r12_load_fault_excl: assert property (@(posedge clk) disable iff (rst)
        !(pc_load && fault));

    // R11: level holds when nothing was requested
    a_r11_level_hold: assert property (@(posedge clk) disable iff (rst)
        (!take_req && !ret_req) |=> $stable(cur_lvl));

    // R2: accepted take never lowers the level and picks the own stack
    a_r2_take_raise: assert property (@(posedge clk) disable iff (rst)
        (pc_load && $past(take_req)) |-> (sp_own && cur_lvl >= $past(cur_lvl)));

    // R6 / R8: refused request leaves the state untouched
    a_r6_fault_hold: assert property (@(posedge clk) disable iff (rst)
        fault |-> ($stable(cur_lvl) && $stable(cur_is64) && $stable(sp_own)));

    // R8: a return never widens from 32-bit to 64-bit
    a_r8_no_widen_on_ret: assert property (@(posedge clk) disable iff (rst)
        (pc_load && $past(ret_req) && !$past(take_req)) |-> !(cur_is64 && !$past(cur_is64)));

    // R7: level 0 always runs on the shared stack
    a_r7_lvl0_shared_stack: assert property (@(posedge clk) disable iff (rst)
        (cur_lvl == 2'd0) |-> !sp_own);

endmodule

bind priv_exc_ctrl pxc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .take_req (take_req),
    .ret_req  (ret_req),
    .pc_load  (pc_load),
    .fault    (fault),
    .cur_lvl  (cur_lvl),
    .cur_is64 (cur_is64),
    .sp_own   (sp_own)
);

// File: tb/priv_exc_ctrl_test.sv
module priv_exc_ctrl_test;

    localparam int unsigned AW = 32;
    localparam int unsigned NL = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          take_req = 1'b0;
    logic [1:0]    exc_kind = '0;
    logic [1:0]    take_lvl = '0;
    logic [AW-1:0] ret_pc = '0;
    logic          ret_req = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [1:0]    cfg_lvl = '0;
    logic [AW-1:0] cfg_data = '0;
    logic          pc_load;
    logic [AW-1:0] pc_out;
    logic [1:0]    cur_lvl;
    logic          cur_is64;
    logic          sp_own;
    logic          fault;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [1:0]    m_lvl;
    logic          m_is64, m_sp;
    logic [AW-1:0] m_vb [4];
    logic          m_vbv [4];
    logic [3:0]    m_sv [4];
    logic [AW-1:0] m_ra [4];

    always #5 clk = ~clk;

    priv_exc_ctrl #(.AW(AW), .HAS_L2(1'b1), .HAS_L3(1'b1), .NARROW_LEVELS(NL)) uut (
        .clk(clk), .rst(rst), .take_req(take_req), .exc_kind(exc_kind), .take_lvl(take_lvl),
        .ret_pc(ret_pc), .ret_req(ret_req), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_lvl(cfg_lvl), .cfg_data(cfg_data), .pc_load(pc_load), .pc_out(pc_out),
        .cur_lvl(cur_lvl), .cur_is64(cur_is64), .sp_own(sp_own), .fault(fault)
    );

    function automatic logic [AW-1:0] vec_expect(input logic [AW-1:0] vb, input logic [1:0] k,
                                                 input bit same_own);
        logic [10:0] off;
        off = 11'(k) * 11'h80 + (same_own ? 11'h200 : 11'h000);
        return {vb[AW-1:11], off};
    endfunction

    task automatic check(input string req, input logic e_pcl, input logic [AW-1:0] e_pc,
                         input logic e_flt);
        n_tests++;
        if (pc_load !== e_pcl || fault !== e_flt || cur_lvl !== m_lvl || cur_is64 !== m_is64
            || sp_own !== m_sp || (e_pcl && pc_out !== e_pc)) begin
            n_fail++;
            $display("FAIL %s: got load=%0b pc=%h flt=%0b lvl=%0d w64=%0b sp=%0b exp load=%0b pc=%h flt=%0b lvl=%0d w64=%0b sp=%0b",
                     req, pc_load, pc_out, fault, cur_lvl, cur_is64, sp_own,
                     e_pcl, e_pc, e_flt, m_lvl, m_is64, m_sp);
        end
    endtask

    task automatic step(input string req, input bit tk, input logic [1:0] kind, input logic [1:0] tl,
                        input logic [AW-1:0] rp, input bit rt, input bit cw, input logic [1:0] cs,
                        input logic [1:0] cl, input logic [AW-1:0] cd);
        logic          tok, rok, e_pcl, e_flt;
        logic [AW-1:0] e_pc;
        logic [3:0]    sv;
        @(negedge clk);
        take_req = tk; exc_kind = kind; take_lvl = tl; ret_pc = rp; ret_req = rt;
        cfg_wr = cw; cfg_sel = cs; cfg_lvl = cl; cfg_data = cd;
        sv  = m_sv[m_lvl];
        tok = (tl != 0) && (tl >= m_lvl) && m_vbv[tl];
        rok = (m_lvl != 0) && (sv[1:0] <= m_lvl) && (sv[2] || sv[1:0] < NL) && !(sv[2] && !m_is64);
        e_pcl = 1'b0; e_flt = 1'b0; e_pc = '0;
        if (tk) begin
            if (tok) begin
                e_pcl = 1'b1;
                e_pc  = vec_expect(m_vb[tl], kind, (tl == m_lvl) && m_sp);
                m_sv[tl] = {m_sp, m_is64, m_lvl};
                m_ra[tl] = rp;
                m_lvl  = tl;
                m_is64 = m_is64 || !(tl < NL);
                m_sp   = 1'b1;
            end else e_flt = 1'b1;
        end else if (rt) begin
            if (rok) begin
                e_pcl  = 1'b1;
                e_pc   = m_ra[m_lvl];
                m_lvl  = sv[1:0];
                m_is64 = sv[2];
                m_sp   = (sv[1:0] != 0) && sv[3];
            end else e_flt = 1'b1;
        end
        if (cw && cl != 0) begin
            if (cs == 2'd0) begin m_vb[cl] = cd; m_vbv[cl] = 1'b1; end
            else if (!(tk && tok && tl == cl)) begin
                if (cs == 2'd1) m_sv[cl] = cd[3:0];
                if (cs == 2'd2) m_ra[cl] = cd;
            end
        end
        @(posedge clk);
        #1;
        take_req = 0; ret_req = 0; cfg_wr = 0;
        check(req, e_pcl, e_pc, e_flt);
    endtask

    task automatic cfg(input string req, input logic [1:0] cs, input logic [1:0] cl,
                       input logic [AW-1:0] cd);
        step(req, 0, 0, 0, 0, 0, 1, cs, cl, cd);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        m_lvl = 2'd3; m_is64 = 1'b1; m_sp = 1'b1;
        for (int i = 0; i < 4; i++) begin
            m_vb[i] = '0; m_vbv[i] = 1'b0; m_sv[i] = '0; m_ra[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state", 1'b0, '0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 first cycle after reset", 1'b0, '0, 1'b0);

        step("R6 take before vector base written", 1, 0, 3, 32'h10, 0, 0, 0, 0, 0);
        cfg("R10 vector base level 1", 0, 1, 32'h0001_0000);
        cfg("R10 vector base level 2", 0, 2, 32'h0002_07FF);
        cfg("R10 vector base level 3", 0, 3, 32'h0003_0000);
        step("R3 same level own stack IRQ", 1, 1, 3, 32'h100, 0, 0, 0, 0, 0);
        step("R6 take to lower level", 1, 0, 2, 32'h104, 0, 0, 0, 0, 0);
        step("R6 take to level 0", 1, 0, 0, 32'h108, 0, 0, 0, 0, 0);
        cfg("R10 saved word level 3", 1, 3, 32'h5);
        cfg("R10 return address level 3", 2, 3, 32'hABCD_0000);
        step("R7 return to level 1", 0, 0, 0, 0, 1, 0, 0, 0, 0);
        step("R3 same level shared stack sync", 1, 0, 1, 32'h200, 0, 0, 0, 0, 0);
        step("R3 same level own stack fast", 1, 2, 1, 32'h204, 0, 0, 0, 0, 0);
        step("R4 return restores saved by take", 0, 0, 0, 0, 1, 0, 0, 0, 0);
        cfg("R10 saved word level 1", 1, 1, 32'h8);
        step("R7 return to level 0 forces shared stack", 0, 0, 0, 0, 1, 0, 0, 0, 0);
        step("R8 return from level 0", 0, 0, 0, 0, 1, 0, 0, 0, 0);
        step("R5 take to level 1 stays 32-bit", 1, 3, 1, 32'h300, 0, 0, 0, 0, 0);
        step("R5 take to level 2 widens", 1, 0, 2, 32'h304, 0, 0, 0, 0, 0);
        cfg("R10 saved word level 2 higher", 1, 2, 32'h7);
        step("R8 return to higher level", 0, 0, 0, 0, 1, 0, 0, 0, 0);
        cfg("R10 saved word level 2 narrow", 1, 2, 32'h2);
        step("R8 return narrow at wide-only level", 0, 0, 0, 0, 1, 0, 0, 0, 0);
        step("R9 take wins over return", 1, 3, 2, 32'h400, 1, 0, 0, 0, 0);
        cfg("R10 saved word level 2 to 32-bit level 1", 1, 2, 32'h1);
        step("R7 return to 32-bit level 1", 0, 0, 0, 0, 1, 0, 0, 0, 0);
        cfg("R10 saved word level 1 wide", 1, 1, 32'h4);
        step("R8 return widening forbidden", 0, 0, 0, 0, 1, 0, 0, 0, 0);

        for (int n = 0; n < 4000; n++) begin
            int unsigned r;
            r = $urandom % 100;
            if (r < 45)
                step("R2 R3 R5 R6 random take", 1, 2'($urandom), 2'($urandom), $urandom, 0, 0, 0, 0, 0);
            else if (r < 70)
                step("R4 R7 R8 random return", 0, 0, 0, 0, 1, 0, 0, 0, 0);
            else if (r < 90)
                cfg("R10 random write", 2'($urandom % 3), 2'($urandom), $urandom);
            else if (r < 95)
                step("R9 random both", 1, 2'($urandom), 2'($urandom), $urandom, 1, 0, 0, 0, 0);
            else
                step("R11 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
    end

endmodule